// File: doc/BRIEF.md
# Multifunction 32-bit Arithmetic/Logic Unit

This block is a purely combinational datapath unit. It takes two 32-bit operands and a small set of control fields, and it returns one 32-bit result together with an overflow flag and a zero flag. Inside it are four function units:

- an adder/subtractor built on a parallel-prefix carry network;
- a logarithmic barrel shifter that shifts the second operand;
- a bitwise logic unit;
- a signed comparison that produces a one-bit answer widened to a full word.

A two-bit class field picks which unit drives the result.

The shift distance comes from one of two places: a 5-bit constant input, or the low five bits of the first operand. The caller can therefore shift by an immediate value or by a register value without extra muxing outside the block. The zero flag reflects the selected result in every class. The overflow flag is reported only for arithmetic operations.

Top module: `alu32_mf`

## Requirements
- R1: `cls` selects the result source: 2'b00 selects the shifter, 2'b01 the signed less-than compare, 2'b10 the adder/subtractor and 2'b11 the logic unit.
- R2: In the logic class, `lg_fn` selects the bitwise function of `opa` and `opb`: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 NOR.
- R3: In the arithmetic class, `sub_en`=0 gives `opa+opb` modulo 2^32 and `sub_en`=1 gives `opa-opb` modulo 2^32, formed by inverting `opb` with a carry-in of one.
- R4: `ovfl` is the carry into bit 31 XOR the carry out of bit 31, which is two's-complement overflow of the add or subtract. It is driven only in the arithmetic class and reads 0 in every other class.
- R5: In the shift class, `sh_fn` acts on `opb`: 2'b00 returns `opb` unchanged, 2'b01 shifts left logical, 2'b10 shifts right logical and 2'b11 shifts right arithmetic, copying bit 31.
- R6: The shift distance is `shamt_k` when `amt_var`=0 and `opa[4:0]` when `amt_var`=1.
- R7: The compare class returns 32'd1 when `opa` is less than `opb` as signed numbers and 32'd0 otherwise. The block always subtracts internally for this class, whatever `sub_en` is, and it corrects the sign of the difference with overflow.
- R8: `zero` is 1 exactly when all 32 bits of `res` are 0, in every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand; its low 5 bits can also give the shift distance |
| opb | input | 32 | Second operand; this is the value the shifter moves |
| shamt_k | input | 5 | Constant shift distance |
| cls | input | 2 | Function class select |
| sub_en | input | 1 | Subtract instead of add, in the arithmetic class |
| amt_var | input | 1 | Take the shift distance from `opa[4:0]` |
| sh_fn | input | 2 | Shift function |
| lg_fn | input | 2 | Logic function |
| res | output | 32 | Result |
| ovfl | output | 1 | Signed overflow, arithmetic class only |
| zero | output | 1 | Result is all zeros |

## Verification
In the arithmetic class, overflow and a zero result can occur in the same cycle. Adding 0x80000000 to itself wraps to zero and also overflows, so both flags must be raised together. The compare class meets overflow as well: in 0x7FFFFFFF against 0x80000000 and the reverse, the raw difference sign is wrong and must be corrected. The bench produces both situations by crossing a set of corner operands (0, 1, -1, 0x80000000, 0x7FFFFFFF, 0x7FFFFFFE) with every class and function code. On each cycle it compares `res`, `ovfl` and `zero` separately against a behavioural model that uses native signed arithmetic.

// File: rtl/alu32_mf.sv
module alu32_mf #(
  parameter int W = 32
) (
  input  logic [W-1:0]         opa,
  input  logic [W-1:0]         opb,
  input  logic [$clog2(W)-1:0] shamt_k,
  input  logic [1:0]           cls,
  input  logic                 sub_en,
  input  logic                 amt_var,
  input  logic [1:0]           sh_fn,
  input  logic [1:0]           lg_fn,
  output logic [W-1:0]         res,
  output logic                 ovfl,
  output logic                 zero
);
  localparam int LW = $clog2(W);

  // adder / subtractor with parallel-prefix carries
  logic         do_sub;
  logic [W-1:0] bop, g0, p0, gfin, pfin, sum;
  logic [W:0]   cv;
  logic         ov_raw, lt_bit;

  assign do_sub = sub_en | (cls == 2'b01);
  assign bop    = opb ^ {W{do_sub}};
  assign g0     = opa & bop;
  assign p0     = opa ^ bop;

  for (genvar lv = 0; lv < LW; lv++) begin : pfx
    localparam int D = 1 << lv;
    logic [W-1:0] gi, pi_, go, po;
    if (lv == 0) begin : src0
      assign gi  = g0;
      assign pi_ = p0;
    end else begin : srcn
      assign gi  = pfx[lv-1].go;
      assign pi_ = pfx[lv-1].po;
    end
    for (genvar i = 0; i < W; i++) begin : col
      if (i >= D) begin : mrg
        assign go[i] = gi[i] | (pi_[i] & gi[i-D]);
        assign po[i] = pi_[i] & pi_[i-D];
      end else begin : pas
        assign go[i] = gi[i];
        assign po[i] = pi_[i];
      end
    end
  end

  assign gfin  = pfx[LW-1].go;
  assign pfin  = pfx[LW-1].po;
  assign cv[0] = do_sub;
  for (genvar i = 0; i < W; i++) begin : cry
    assign cv[i+1] = gfin[i] | (pfin[i] & do_sub);
  end
  assign sum    = p0 ^ cv[W-1:0];
  assign ov_raw = cv[W] ^ cv[W-1];
  assign lt_bit = sum[W-1] ^ ov_raw;

  // barrel shifter on opb
  logic [LW-1:0] amt, eff;
  logic          go_left, fill;
  logic [W-1:0]  shv;

  assign amt     = amt_var ? opa[LW-1:0] : shamt_k;
  assign eff     = (sh_fn == 2'b00) ? '0 : amt;
  assign go_left = (sh_fn == 2'b01);
  assign fill    = (sh_fn == 2'b11) & opb[W-1];

  for (genvar k = 0; k < LW; k++) begin : shs
    localparam int S = 1 << k;
    logic [W-1:0] din, dout;
    if (k == 0) begin : src0
      assign din = opb;
    end else begin : srcn
      assign din = shs[k-1].dout;
    end
    assign dout = !eff[k] ? din :
                  go_left ? {din[W-1-S:0], {S{1'b0}}} :
                            {{S{fill}}, din[W-1:S]};
  end
  assign shv = shs[LW-1].dout;

  // logic unit
  logic [W-1:0] lgv;
  always_comb begin
    case (lg_fn)
      2'b00:   lgv = opa & opb;
      2'b01:   lgv = opa | opb;
      2'b10:   lgv = opa ^ opb;
      default: lgv = ~(opa | opb);
    endcase
  end

  // class select and flags
  always_comb begin
    case (cls)
      2'b00:   res = shv;
      2'b01:   res = {{(W-1){1'b0}}, lt_bit};
      2'b10:   res = sum;
      default: res = lgv;
    endcase
  end

  assign ovfl = (cls == 2'b10) & ov_raw;
  assign zero = ~|res;

  always_comb begin
    if (cls != 2'b10) AST_OVFL_CLASS: assert (!ovfl); // R4
    if (cls == 2'b01) AST_SLT_RANGE: assert (res[W-1:1] == '0); // R7
    if (cls == 2'b00 && sh_fn == 2'b00) AST_NOSHIFT_PASS: assert (res == opb); // R5
    if (cls == 2'b10 && sub_en && opa == opb) AST_SELF_SUB_ZERO: assert (zero && !ovfl); // R3
    if (cls == 2'b11 && lg_fn == 2'b10 && opa == opb) AST_XOR_SAME_ZERO: assert (zero); // R8
  end
endmodule

// File: tb/alu32_mf_tb_top.sv
module alu32_mf_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] opa, opb, res;
  logic [4:0]  shamt_k;
  logic [1:0]  cls, sh_fn, lg_fn;
  logic        sub_en, amt_var, ovfl, zero;
  int checks = 0;
  int fails  = 0;

  alu32_mf dut_i (
    .opa(opa), .opb(opb), .shamt_k(shamt_k), .cls(cls), .sub_en(sub_en),
    .amt_var(amt_var), .sh_fn(sh_fn), .lg_fn(lg_fn),
    .res(res), .ovfl(ovfl), .zero(zero)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cls=%0d a=%h b=%h: actual %h expected %h", tag, cls, opa, opb, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [4:0] k,
                       input logic [1:0] c, input logic sb, input logic av,
                       input logic [1:0] sf, input logic [1:0] lf);
    logic [31:0] er;
    logic        eo, ez;
    logic [4:0]  am;
    string       tag;
    @(posedge clk);
    opa = a; opb = b; shamt_k = k; cls = c; sub_en = sb; amt_var = av; sh_fn = sf; lg_fn = lf;
    am = av ? a[4:0] : k;
    eo = 1'b0;
    case (c)
      2'b00: begin
        tag = "R1 R5 R6";
        case (sf)
          2'b00: er = b;
          2'b01: er = b << am;
          2'b10: er = b >> am;
          default: er = $unsigned($signed(b) >>> am);
        endcase
      end
      2'b01: begin
        tag = "R1 R7";
        er = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      end
      2'b10: begin
        tag = "R1 R3";
        er = sb ? a - b : a + b;
        eo = sb ? (a[31] != b[31] && er[31] != a[31]) : (a[31] == b[31] && er[31] != a[31]);
      end
      default: begin
        tag = "R1 R2";
        case (lf)
          2'b00: er = a & b;
          2'b01: er = a | b;
          2'b10: er = a ^ b;
          default: er = ~(a | b);
        endcase
      end
    endcase
    ez = (er == 32'd0);
    @(negedge clk);
    chk(tag, res, er);
    chk("R4 ovfl", {31'd0, ovfl}, {31'd0, eo});
    chk("R8 zero", {31'd0, zero}, {31'd0, ez});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] corners [6];
    corners[0] = 32'h0;        corners[1] = 32'h1;        corners[2] = 32'hFFFFFFFF;
    corners[3] = 32'h80000000; corners[4] = 32'h7FFFFFFF; corners[5] = 32'h7FFFFFFE;
    opa = '0; opb = '0; shamt_k = '0; cls = '0; sub_en = 0; amt_var = 0; sh_fn = '0; lg_fn = '0;
    // initial all-zero inputs: shift class passes zero, zero flag set
    apply(32'h0, 32'h0, 5'd0, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00);
    // R4 and R8 together: overflow that wraps to zero
    apply(32'h80000000, 32'h80000000, 5'd0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
    // R7 overflow-corrected compares, with sub_en low
    apply(32'h7FFFFFFF, 32'h80000000, 5'd0, 2'b01, 1'b0, 1'b0, 2'b00, 2'b00);
    apply(32'h80000000, 32'h7FFFFFFF, 5'd0, 2'b01, 1'b0, 1'b0, 2'b00, 2'b00);
    // R6 edge distances from both sources
    apply(32'h0000001F, 32'h80000001, 5'd0,  2'b00, 1'b0, 1'b1, 2'b11, 2'b00);
    apply(32'h00000000, 32'h80000001, 5'd31, 2'b00, 1'b0, 1'b0, 2'b10, 2'b00);
    apply(32'hFFFFFFE0, 32'h80000001, 5'd7,  2'b00, 1'b0, 1'b1, 2'b01, 2'b00);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int c = 0; c < 4; c++)
          for (int s = 0; s < 2; s++)
            for (int f = 0; f < 4; f++)
              apply(corners[i], corners[j], 5'(i * 6 + j), 2'(c), 1'(s), 1'(f[0] ^ s), 2'(f), 2'(f));
    for (int n = 0; n < 4000; n++)
      apply($urandom, $urandom, 5'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
            2'($urandom), 2'($urandom));
    summary();
    $finish;
  end
endmodule